// File: doc/BRIEF.md
# Channel Program Sequencer

This block runs a channel program on behalf of one subchannel. A start request carries an address word holding a storage key and the location of the first command word. The sequencer fetches 8-byte command words from memory, checks and decodes them, and hands each command's code, data address, byte count and skip flag to a device port. It then collects the device's ending status and the number of bytes moved, and decides whether to continue under the chaining rules. It also decides whether to repeat or skip a word, and when to stop.

When the program stops, the block assembles a 64-bit channel status word and pulses a completion interrupt. The status word holds the key, the address just past the last fetched word, the device's unit status, the channel's own status and the residual count. A command word can also ask for a progress interrupt when it is fetched; the program keeps running when it does. Memory and device are simple request/response ports. Data bytes are not moved by this block: the device reports only how many it transferred.

Bit numbering in this brief follows the architectural convention: bit 0 is the most significant bit of a word. Bit n of a 64-bit word is vector bit 63-n, and bit n of the 32-bit address word is vector bit 31-n.

Top module: `ccw_sequencer`

## Requirements
- R1: While idle, a pulse on `start_valid` latches the key (address-word bits 0-3) and the first word address (bits 8-31) and raises `busy`. A start pulse while busy is ignored. After reset `busy`, `mem_req`, `dev_cmd_valid`, `done_irq` and `pci_irq` are 0.
- R2: Each command word is fetched by holding `mem_req` with a stable, doubleword-aligned `mem_addr` until `mem_rsp_valid`. Words follow one another at consecutive doublewords unless a branch or skip applies.
- R3: A command word holds the command code in bits 0-7, the data address in 8-31, the flags in 32-36 and the count in 48-63. The flags are chain-data (32), chain-command (33), suppress-length (34), skip (35) and progress interrupt (36). An accepted word is presented for one cycle on `dev_cmd_valid` together with its code, address, count and skip flag.
- R4: A word whose code has low nibble 1000 is a branch: the next word is fetched from its address field. A branch reached straight from the address word, or from another branch, ends the program with program check and issues no command.
- R5: A word without chain-command or chain-data ends the program when the device reports its ending status. `done_irq` then pulses once and `busy` falls.
- R6: With chain-command set and a clean ending, the next word at the following doubleword is fetched and its command issued.
- R7: Unit check (unit-status bit 38) or unit exception (bit 39) in the ending status stops the program even when chaining is requested.
- R8: Unit check together with status modifier (bit 33) re-issues the same command without fetching a new word.
- R9: Status modifier without unit check, on a word with chain-command, skips one word: the next fetch is 16 bytes past the current word.
- R10: If the device transfers fewer bytes than the count, incorrect length (status bit 41) is set and the program stops, unless suppress-length is set. The residual (count minus transferred, floored at 0) is reported either way.
- R11: An accepted word with the progress flag pulses `pci_irq` at fetch time, and status bit 40 is set in the final status word. The program goes on.
- R12: A nonzero value in bits 37-47 of a non-branch word, a code with low nibble 0000 on a non-data-chained word, or a nonzero address-word bit 4-7 or misaligned address ends the program. It reports program check (status bit 42) with zero unit status and zero residual, and no command goes to the device. For an address-word fault, the address field is the address-word address.
- R13: The completion status word carries the key in bits 0-3, zeros in 4-7, the last fetched word address plus 8 in 8-31, the unit status in 32-39, the channel status in 40-47 and the residual in 48-63.
- R14: With chain-data set and a clean ending, the next word supplies a new address and count. The previous command code is kept, and `dev_chain_data` is raised with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request pulse |
| start_caw | input | 32 | Address word: key and first command word address |
| busy | output | 1 | A channel program is running |
| mem_req | output | 1 | Command word fetch request, held until response |
| mem_addr | output | 24 | Doubleword address of the word being fetched |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 64 | Fetched command word |
| dev_cmd_valid | output | 1 | One-cycle command presentation |
| dev_cmd_code | output | 8 | Command code |
| dev_data_addr | output | 24 | Data address for the command |
| dev_count | output | 16 | Byte count for the command |
| dev_skip | output | 1 | Transfer without touching storage |
| dev_chain_data | output | 1 | Command continues the previous data transfer |
| dev_end_valid | input | 1 | Ending status valid |
| dev_unit_status | input | 8 | Unit status byte (architectural bits 32-39) |
| dev_xfer_count | input | 16 | Bytes actually transferred |
| pci_irq | output | 1 | Progress interrupt pulse |
| done_irq | output | 1 | Program-complete interrupt pulse |
| csw | output | 64 | Channel status word |

## Verification
Every cycle, the assertions check the fetch handshake: the request is held with an aligned, steady address. They also check that commands appear as single pulses and that no null or branch code reaches the device. At completion they check the zero field and the clean unit byte on program check, the falling busy, and the progress bit. The chaining decisions can only be shown by the bench's scenarios, which compare the commands the device saw and the final status word against values built from the rules. Those decisions are branching, skip, retry, suppression by unit check, incorrect length against suppress-length, and data chaining. A sweep over all 256 command codes covers the decode, invalid-code and branch-from-start paths.

// File: rtl/ccw_sequencer.sv
module ccw_sequencer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  input  logic [31:0] start_caw,
  output logic        busy,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        dev_cmd_valid,
  output logic [7:0]  dev_cmd_code,
  output logic [23:0] dev_data_addr,
  output logic [15:0] dev_count,
  output logic        dev_skip,
  output logic        dev_chain_data,
  input  logic        dev_end_valid,
  input  logic [7:0]  dev_unit_status,
  input  logic [15:0] dev_xfer_count,
  output logic        pci_irq,
  output logic        done_irq,
  output logic [63:0] csw
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_ISSUE, S_WAIT} st_t;

  st_t         st;
  logic [3:0]  key_q;
  logic [23:0] fetch_a, last_a, data_a;
  logic [15:0] cnt_q;
  logic [7:0]  code_q;
  logic [63:0] word_q;
  logic [4:0]  flg_q;
  logic        prev_tic, dchain, pci_seen;

  wire [7:0]  w_code = word_q[63:56];
  wire [23:0] w_addr = word_q[55:32];
  wire [4:0]  w_flg  = word_q[31:27];
  wire [10:0] w_rsvd = word_q[26:16];
  wire [15:0] w_cnt  = word_q[15:0];

  wire w_tic     = (w_code[3:0] == 4'b1000);
  wire w_null    = (w_code[3:0] == 4'b0000) && !dchain;
  wire w_bad     = (w_rsvd != 11'd0) || w_null;
  wire tic_bad   = prev_tic || (w_addr[2:0] != 3'd0);
  wire caw_bad   = (start_caw[27:24] != 4'd0) || (start_caw[2:0] != 3'd0);

  wire f_cd  = flg_q[4];
  wire f_cc  = flg_q[3];
  wire f_sli = flg_q[2];

  wire        u_sm = dev_unit_status[6];
  wire        u_uc = dev_unit_status[1];
  wire        u_ue = dev_unit_status[0];
  wire [15:0] resid = (dev_xfer_count >= cnt_q) ? 16'd0 : cnt_q - dev_xfer_count;
  wire        il    = (resid != 16'd0) && !f_sli;
  wire [23:0] next_a = last_a + 24'd8;
  wire [23:0] skip_a = last_a + 24'd16;

  wire [7:0]  ch_end = {pci_seen, il, 6'd0};
  wire [7:0]  ch_pc  = {pci_seen, 1'b0, 1'b1, 5'd0};

  assign busy           = (st != S_IDLE);
  assign mem_req        = (st == S_FETCH);
  assign mem_addr       = fetch_a;
  assign dev_cmd_valid  = (st == S_ISSUE);
  assign dev_cmd_code   = code_q;
  assign dev_data_addr  = data_a;
  assign dev_count      = cnt_q;
  assign dev_skip       = flg_q[1];
  assign dev_chain_data = dchain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      key_q    <= '0;
      fetch_a  <= '0;
      last_a   <= '0;
      data_a   <= '0;
      cnt_q    <= '0;
      code_q   <= '0;
      word_q   <= '0;
      flg_q    <= '0;
      prev_tic <= 1'b0;
      dchain   <= 1'b0;
      pci_seen <= 1'b0;
      pci_irq  <= 1'b0;
      done_irq <= 1'b0;
      csw      <= '0;
    end else begin
      pci_irq  <= 1'b0;
      done_irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_valid) begin
            key_q <= start_caw[31:28];
            if (caw_bad) begin
              csw      <= {start_caw[31:28], 4'd0, start_caw[23:0], 8'd0, 8'h20, 16'd0};
              done_irq <= 1'b1;
            end else begin
              fetch_a  <= start_caw[23:0];
              prev_tic <= 1'b1;
              dchain   <= 1'b0;
              pci_seen <= 1'b0;
              st       <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (mem_rsp_valid) begin
            word_q <= mem_rsp_data;
            last_a <= fetch_a;
            st     <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (w_tic && !tic_bad) begin
            fetch_a  <= w_addr;
            prev_tic <= 1'b1;
            st       <= S_FETCH;
          end else if (w_tic || w_bad) begin
            csw      <= {key_q, 4'd0, next_a, 8'd0, ch_pc, 16'd0};
            done_irq <= 1'b1;
            st       <= S_IDLE;
          end else begin
            prev_tic <= 1'b0;
            flg_q    <= w_flg;
            data_a   <= w_addr;
            cnt_q    <= w_cnt;
            if (!dchain) code_q <= w_code;
            if (w_flg[0]) begin
              pci_irq  <= 1'b1;
              pci_seen <= 1'b1;
              csw      <= {key_q, 4'd0, next_a, 8'd0, 8'h80, w_cnt};
            end
            st <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (dev_end_valid) begin
            if (u_uc && u_sm) begin
              st <= S_ISSUE;
            end else if (u_uc || u_ue || il || !(f_cd || f_cc)) begin
              csw      <= {key_q, 4'd0, next_a, dev_unit_status, ch_end, resid};
              done_irq <= 1'b1;
              st       <= S_IDLE;
            end else if (f_cd) begin
              dchain  <= 1'b1;
              fetch_a <= next_a;
              st      <= S_FETCH;
            end else begin
              dchain  <= 1'b0;
              fetch_a <= u_sm ? skip_a : next_a;
              st      <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr));

  p_fetch_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'd0);

  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cmd_valid |=> !dev_cmd_valid);

  p_no_null_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cmd_valid && !dev_chain_data |-> dev_cmd_code[3:0] != 4'd0 && dev_cmd_code[3:0] != 4'd8);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  p_csw_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> csw[59:56] == 4'd0);

  p_pc_no_unit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq && csw[21] |-> csw[31:24] == 8'd0);

  p_pci_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pci_irq |-> csw[23] && busy);

endmodule

// File: tb/sim_ccw_sequencer.sv
module sim_ccw_sequencer;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        start_valid = 0;
  logic [31:0] start_caw = 0;
  logic        busy, mem_req, mem_rsp_valid = 0;
  logic [23:0] mem_addr;
  logic [63:0] mem_rsp_data = 0;
  logic        dev_cmd_valid, dev_skip, dev_chain_data;
  logic [7:0]  dev_cmd_code;
  logic [23:0] dev_data_addr;
  logic [15:0] dev_count;
  logic        dev_end_valid = 0;
  logic [7:0]  dev_unit_status = 0;
  logic [15:0] dev_xfer_count = 0;
  logic        pci_irq, done_irq;
  logic [63:0] csw;

  ccw_sequencer u0 (.*);

  localparam logic [4:0] FCD = 5'b10000, FCC = 5'b01000, FSLI = 5'b00100,
                         FSKIP = 5'b00010, FPCI = 5'b00001;

  logic [63:0] mem [0:31];
  logic [7:0]  rsp_us [0:7];
  logic [15:0] rsp_xf [0:7];
  logic [7:0]  lg_code [0:7];
  logic [23:0] lg_addr [0:7];
  logic [15:0] lg_cnt [0:7];
  logic        lg_cd [0:7], lg_skip [0:7];
  logic [23:0] fa [0:7];
  int ncmd = 0, nf = 0, npci = 0, cur = 0, dly = 0, cyc = 0;
  int nchk = 0, nfail = 0;
  bit got_done = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req && !mem_rsp_valid;
    mem_rsp_data  <= mem[mem_addr[7:3]];
    if (mem_req && !mem_rsp_valid) begin fa[nf[2:0]] <= mem_addr; nf <= nf + 1; end
    if (pci_irq) npci <= npci + 1;
    if (done_irq) got_done <= 1;
  end

  always @(posedge clk) begin
    dev_end_valid <= 0;
    if (dev_cmd_valid) begin
      lg_code[ncmd[2:0]] <= dev_cmd_code;
      lg_addr[ncmd[2:0]] <= dev_data_addr;
      lg_cnt[ncmd[2:0]]  <= dev_count;
      lg_cd[ncmd[2:0]]   <= dev_chain_data;
      lg_skip[ncmd[2:0]] <= dev_skip;
      cur  <= ncmd;
      ncmd <= ncmd + 1;
      dly  <= 2;
    end else if (dly == 1) begin
      dev_end_valid   <= 1;
      dev_unit_status <= rsp_us[cur[2:0]];
      dev_xfer_count  <= rsp_xf[cur[2:0]];
      dly <= 0;
    end else if (dly > 1) dly <= dly - 1;
  end

  function automatic logic [63:0] mk(input logic [7:0] c, input logic [23:0] a,
                                     input logic [4:0] f, input logic [15:0] n);
    return {c, a, f, 11'd0, n};
  endfunction

  function automatic logic [63:0] cw(input logic [3:0] k, input logic [23:0] a,
                                     input logic [7:0] us, input logic [7:0] cs, input logic [15:0] n);
    return {k, 4'd0, a, us, cs, n};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 32; i++) mem[i] = 64'd0;
    for (int i = 0; i < 8; i++) begin rsp_us[i] = 8'h0C; rsp_xf[i] = 16'hFFFF; end
    ncmd = 0; nf = 0; npci = 0;
  endtask

  task automatic run(input logic [31:0] caw);
    @(negedge clk);
    got_done = 0;
    start_valid = 1; start_caw = caw;
    @(negedge clk);
    start_valid = 0;
    for (int i = 0; i < 400; i++) begin
      if (got_done) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, mem_req, dev_cmd_valid, done_irq, pci_irq}, 5'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 1'b0);

    // R3 R4 R12: sweep all command codes on a single word
    for (int c = 0; c < 256; c++) begin
      clr();
      mem[0] = mk(c[7:0], 24'h100, 5'd0, 16'd20);
      run({4'h5, 4'h0, 24'h0});
      if (c[3:0] == 4'h0 || c[3:0] == 4'h8) begin
        chk("R12/R4 sweep csw", csw, cw(4'h5, 24'h8, 8'h00, 8'h20, 16'd0));
        chk("R12/R4 sweep no cmd", ncmd, 0);
      end else begin
        chk("R3 sweep csw", csw, cw(4'h5, 24'h8, 8'h0C, 8'h00, 16'd0));
        chk("R3 sweep cmd", {ncmd[7:0], lg_code[0], lg_addr[0], lg_cnt[0]},
            {8'd1, c[7:0], 24'h100, 16'd20});
      end
    end

    // R6 R2 R5: command chaining
    clr();
    mem[0] = mk(8'h01, 24'h200, FCC, 16'd8);
    mem[1] = mk(8'h02, 24'h300, FSKIP, 16'd4);
    run({4'h7, 4'h0, 24'h0});
    chk("R6 cmd count", ncmd, 2);
    chk("R6 codes", {lg_code[0], lg_code[1]}, 16'h0102);
    chk("R3 skip flag", {lg_skip[0], lg_skip[1]}, 2'b01);
    chk("R2 fetch seq", {nf[7:0], fa[0], fa[1]}, {8'd2, 24'h0, 24'h8});
    chk("R5 R13 final csw", csw, cw(4'h7, 24'h10, 8'h0C, 8'h00, 16'd0));
    chk("R5 idle", busy, 1'b0);

    // R4 branch
    clr();
    mem[0] = mk(8'h03, 24'h10, FCC, 16'd1);
    mem[1] = mk(8'h08, 24'h40, 5'd0, 16'd0);
    mem[8] = mk(8'h02, 24'h500, 5'd0, 16'd6);
    run({4'h2, 4'h0, 24'h0});
    chk("R4 branch cmds", {ncmd[7:0], lg_code[1], lg_addr[1]}, {8'd2, 8'h02, 24'h500});
    chk("R4 branch csw", csw, cw(4'h2, 24'h48, 8'h0C, 8'h00, 16'd0));

    // R4 branch to branch
    mem[8] = mk(8'h08, 24'h80, 5'd0, 16'd0);
    clr_keep();
    run({4'h2, 4'h0, 24'h0});
    chk("R4 double branch cmds", ncmd, 1);
    chk("R4 double branch csw", csw, cw(4'h2, 24'h48, 8'h00, 8'h20, 16'd0));

    // R7 unit check / unit exception suppress chaining
    clr();
    mem[0] = mk(8'h01, 24'h0, FCC, 16'd4);
    mem[1] = mk(8'h02, 24'h0, 5'd0, 16'd4);
    rsp_us[0] = 8'h0E;
    run({4'h1, 4'h0, 24'h0});
    chk("R7 unit check stops", ncmd, 1);
    chk("R7 unit check csw", csw, cw(4'h1, 24'h8, 8'h0E, 8'h00, 16'd0));
    clr_keep();
    rsp_us[0] = 8'h0D;
    run({4'h1, 4'h0, 24'h0});
    chk("R7 unit exception stops", ncmd, 1);
    chk("R7 unit exception csw", csw, cw(4'h1, 24'h8, 8'h0D, 8'h00, 16'd0));

    // R8 retry
    clr_keep();
    rsp_us[0] = 8'h4E;
    run({4'h1, 4'h0, 24'h0});
    chk("R8 retry codes", {ncmd[7:0], lg_code[0], lg_code[1], lg_code[2]}, {8'd3, 24'h010102});
    chk("R8 retry fetches", nf, 2);
    chk("R8 retry csw", csw, cw(4'h1, 24'h10, 8'h0C, 8'h00, 16'd0));

    // R9 status-modifier skip
    clr();
    mem[0] = mk(8'h01, 24'h0, FCC, 16'd4);
    mem[1] = mk(8'h11, 24'h0, 5'd0, 16'd4);
    mem[2] = mk(8'h22, 24'h0, 5'd0, 16'd4);
    rsp_us[0] = 8'h4C;
    run({4'h3, 4'h0, 24'h0});
    chk("R9 skipped word", {ncmd[7:0], lg_code[1]}, {8'd2, 8'h22});
    chk("R9 skip csw", csw, cw(4'h3, 24'h18, 8'h0C, 8'h00, 16'd0));

    // R10 incorrect length
    clr();
    mem[0] = mk(8'h02, 24'h100, FCC, 16'd10);
    mem[1] = mk(8'h01, 24'h0, 5'd0, 16'd7);
    rsp_xf[0] = 16'd6;
    run({4'h4, 4'h0, 24'h0});
    chk("R10 short stops", ncmd, 1);
    chk("R10 short csw", csw, cw(4'h4, 24'h8, 8'h0C, 8'h40, 16'd4));
    clr_keep();
    mem[0] = mk(8'h02, 24'h100, FCC | FSLI, 16'd10);
    rsp_xf[0] = 16'd6; rsp_xf[1] = 16'd7;
    run({4'h4, 4'h0, 24'h0});
    chk("R10 suppressed chains", ncmd, 2);
    chk("R10 suppressed csw", csw, cw(4'h4, 24'h10, 8'h0C, 8'h00, 16'd0));
    clr();
    mem[0] = mk(8'h02, 24'h100, FSLI, 16'd10);
    rsp_xf[0] = 16'd6;
    run({4'h4, 4'h0, 24'h0});
    chk("R10 residual kept", csw, cw(4'h4, 24'h8, 8'h0C, 8'h00, 16'd4));

    // R11 progress interrupt
    clr();
    mem[0] = mk(8'h01, 24'h0, FCC | FPCI, 16'd4);
    mem[1] = mk(8'h02, 24'h0, 5'd0, 16'd4);
    run({4'h6, 4'h0, 24'h0});
    chk("R11 pulse count", {npci[7:0], ncmd[7:0]}, {8'd1, 8'd2});
    chk("R11 final csw", csw, cw(4'h6, 24'h10, 8'h0C, 8'h80, 16'd0));

    // R14 data chaining
    clr();
    mem[0] = mk(8'h02, 24'h100, FCD, 16'd4);
    mem[1] = mk(8'h70, 24'h180, 5'd0, 16'd3);
    run({4'h8, 4'h0, 24'h0});
    chk("R14 continuation", {ncmd[7:0], lg_code[1], lg_addr[1], lg_cnt[1], 7'd0, lg_cd[1]},
        {8'd2, 8'h02, 24'h180, 16'd3, 8'd1});
    chk("R14 first not chained", lg_cd[0], 1'b0);
    chk("R14 csw", csw, cw(4'h8, 24'h10, 8'h0C, 8'h00, 16'd0));

    // R12 reserved bits and bad address word
    clr();
    mem[0] = mk(8'h01, 24'h0, 5'd0, 16'd4) | 64'h0000_0000_0080_0000;
    run({4'h9, 4'h0, 24'h0});
    chk("R12 reserved no cmd", ncmd, 0);
    chk("R12 reserved csw", csw, cw(4'h9, 24'h8, 8'h00, 8'h20, 16'd0));
    clr();
    run({4'h6, 4'h1, 24'h40});
    chk("R12 caw zeros", {nf[7:0], csw}, {8'd0, cw(4'h6, 24'h40, 8'h00, 8'h20, 16'd0)});
    run({4'h6, 4'h0, 24'h44});
    chk("R12 caw align", {nf[7:0], csw}, {8'd0, cw(4'h6, 24'h44, 8'h00, 8'h20, 16'd0)});

    // R1 start while busy ignored
    clr();
    mem[0] = mk(8'h01, 24'h0, FCC, 16'd4);
    mem[1] = mk(8'h02, 24'h0, 5'd0, 16'd4);
    @(negedge clk);
    got_done = 0;
    start_valid = 1; start_caw = {4'h3, 4'h0, 24'h0};
    @(negedge clk);
    start_valid = 0;
    chk("R1 busy after start", busy, 1'b1);
    repeat (3) @(negedge clk);
    start_valid = 1; start_caw = {4'h9, 4'h0, 24'h40};
    @(negedge clk);
    start_valid = 0;
    for (int i = 0; i < 400; i++) begin
      if (got_done) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R1 second start ignored", {ncmd[7:0], csw}, {8'd2, cw(4'h3, 24'h10, 8'h0C, 8'h00, 16'd0)});

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic clr_keep();
    for (int i = 0; i < 8; i++) begin rsp_us[i] = 8'h0C; rsp_xf[i] = 16'hFFFF; end
    ncmd = 0; nf = 0; npci = 0;
  endtask
endmodule